// File: doc/BRIEF.md
# Triple-Replica Voting Word Store

This block is a small word-addressed store that keeps every word as three separate replicas and resolves each read by a bitwise two-out-of-three vote. Each bit of the returned word is decided on its own. A transient upset that changes any bits of one replica is therefore hidden from the reader. Upsets spread over different replicas are also hidden, as long as no single bit position is wrong in two replicas. A write always refreshes all three replicas at the same time.

Every read is registered, so data appears one cycle after the request. A disagree flag comes with the data whenever the three replicas were not identical. A read that disagrees while the repair enable is high starts a one-cycle repair. The repair writes the voted word back into all three replicas of that address. A fault-injection port flips chosen bits of one chosen replica so that upsets can be provoked on purpose.

A two-state controller runs the repair. `ST_WATCH` is the resting state. The transition *trigger* moves it to `ST_REPAIR`. A trigger is a read that is not forwarded, finds disagreeing replicas, and is made while `scrub_en` is high. In `ST_REPAIR` the controller issues the write-back. A new trigger in that cycle keeps it in `ST_REPAIR` (*re-trigger*). Without a trigger it goes back to `ST_WATCH` (*release*).

Top module: `tmr_vote_mem`

## Requirements
- R1: After reset, `rd_valid`, `disagree` and `rd_data` are 0, and every replica of every address holds 0.
- R2: A write updates all three replicas of `wr_addr`. `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rd_data` then carries the word that was read. `rd_data` holds its value while no read is made.
- R3: Each output bit is the majority of that bit across the three replicas. Corruption limited to one replica per bit position is masked, even when the corrupted bits lie in different replicas.
- R4: `disagree` is high alongside a read result whose three replicas were not all identical. It is low for identical replicas and in cycles without a read result.
- R5: When two replicas hold the same flipped bit, that bit is returned flipped.
- R6: With `inj_en` high, `inj_sel` values 0, 1 and 2 pick replicas 0, 1 and 2, and `inj_mask` is XORed into that replica at `inj_addr`. `inj_sel` = 3 changes nothing. A user write or a repair to the same address in the same cycle overrides the injection.
- R7: A read and a write to the same address in the same cycle return `wr_data` with `disagree` low.
- R8: A trigger with `scrub_en` high causes all three replicas of that address to be rewritten with the voted word in the next cycle. A read in that next cycle is forwarded the voted word. With `scrub_en` low the mismatch remains.
- R9: A user write to the address under repair, made in the repair cycle, takes precedence over the repair.
- R10: A read in the same cycle as an injection to the same address returns the contents before the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| scrub_en | input | 1 | Allow write-back after a disagreeing read |
| inj_en | input | 1 | Fault-injection request |
| inj_sel | input | 2 | Replica to corrupt (3 = none) |
| inj_addr | input | AW | Address to corrupt |
| inj_mask | input | W | Bits to flip |
| rd_data | output | W | Voted read word |
| rd_valid | output | 1 | Read result present |
| disagree | output | 1 | Replicas differed on this read |

## Verification
Several functions can land on the same clock edge. The repair write-back can meet a user write, an injection or a new read of the same address. An injection can also meet a read or a write of the address it targets. Directed sequences set up each of these coincidences on purpose. A random phase then drives writes, reads, injections and repair enables over four addresses only, so that coincidences happen often. The bench judges every edge against its behavioural model, in which the user write overrides the repair, the repair overrides the injection, and a read sees same-cycle writes but never a same-cycle injection.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REPLICAS = 3;

    typedef enum logic [0:0] {
        ST_WATCH  = 1'b0,
        ST_REPAIR = 1'b1
    } repair_state_e;
endpackage

// File: rtl/tmr_replica.sv
module tmr_replica #(
    parameter int W  = 8,
    parameter int D  = 16,
    parameter int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          fix_en,
    input  logic [AW-1:0] fix_addr,
    input  logic [W-1:0]  fix_data,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [W-1:0]  flip_mask,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rword
);
    logic [W-1:0] store [D];

    // Later assignments win: user write over repair over injection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) store[i] <= '0;
        end else begin
            if (flip_en) store[flip_addr] <= store[flip_addr] ^ flip_mask;
            if (fix_en)  store[fix_addr]  <= fix_data;
            if (we)      store[waddr]     <= wdata;
        end
    end

    assign rword = store[raddr];
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] maj,
    output logic         differ
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    assign differ = (a != b) || (a != c);
endmodule

// File: rtl/tmr_repair_fsm.sv
module tmr_repair_fsm
    import tmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          scrub_en,
    input  logic          trigger,
    input  logic [AW-1:0] trig_addr,
    input  logic [W-1:0]  trig_word,
    output logic          fix_en,
    output logic [AW-1:0] fix_addr,
    output logic [W-1:0]  fix_data
);
    repair_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
        end else if (trigger) begin
            addr_q <= trig_addr;
            word_q <= trig_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH:  if (trigger) state_d = ST_REPAIR;
            ST_REPAIR: state_d = trigger ? ST_REPAIR : ST_WATCH;
            default:   state_d = ST_WATCH;
        endcase
    end

    always_comb begin
        fix_en   = (state_q == ST_REPAIR);
        fix_addr = addr_q;
        fix_data = word_q;
    end

    // R8: a write-back is only ever issued after a read with repair enabled
    a_r8_fix_after_enabled_read: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |-> $past(rd_en && scrub_en));
endmodule

// File: rtl/tmr_vote_mem.sv
module tmr_vote_mem
    import tmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int D  = 16,
    parameter int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          scrub_en,
    input  logic          inj_en,
    input  logic [1:0]    inj_sel,
    input  logic [AW-1:0] inj_addr,
    input  logic [W-1:0]  inj_mask,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic          disagree
);
    logic [W-1:0]  copy_word [REPLICAS];
    logic [W-1:0]  voted;
    logic          differ;
    logic          fix_en;
    logic [AW-1:0] fix_addr;
    logic [W-1:0]  fix_data;
    logic          fwd_wr, fwd_fix, trigger;
    logic [W-1:0]  read_word;
    logic          read_diff;

    for (genvar k = 0; k < REPLICAS; k++) begin : g_copy
        tmr_replica #(.W(W), .D(D), .AW(AW)) u_rep (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_en),
            .waddr    (wr_addr),
            .wdata    (wr_data),
            .fix_en   (fix_en),
            .fix_addr (fix_addr),
            .fix_data (fix_data),
            .flip_en  (inj_en && (inj_sel == 2'(k))),
            .flip_addr(inj_addr),
            .flip_mask(inj_mask),
            .raddr    (rd_addr),
            .rword    (copy_word[k])
        );
    end

    tmr_voter #(.W(W)) u_vote (
        .a     (copy_word[0]),
        .b     (copy_word[1]),
        .c     (copy_word[2]),
        .maj   (voted),
        .differ(differ)
    );

    always_comb begin
        fwd_wr    = wr_en && (wr_addr == rd_addr);
        fwd_fix   = fix_en && (fix_addr == rd_addr);
        read_word = fwd_wr ? wr_data : (fwd_fix ? fix_data : voted);
        read_diff = !fwd_wr && !fwd_fix && differ;
        trigger   = rd_en && read_diff && scrub_en;
    end

    tmr_repair_fsm #(.W(W), .AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .scrub_en (scrub_en),
        .trigger  (trigger),
        .trig_addr(rd_addr),
        .trig_word(read_word),
        .fix_en   (fix_en),
        .fix_addr (fix_addr),
        .fix_data (fix_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            disagree <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            disagree <= rd_en && read_diff;
            if (rd_en) rd_data <= read_word;
        end
    end

    // R2: a result appears exactly one cycle after each read request
    a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R4: the mismatch flag only accompanies a read result
    a_r4_flag_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        disagree |-> rd_valid);
    // R7: same-cycle write is forwarded to the read
    a_r7_write_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && rd_addr == wr_addr) |=> (rd_data == $past(wr_data)) && !disagree);
endmodule

// File: tb/sim_tmr_vote_mem.sv
`timescale 1ns/1ps
module sim_tmr_vote_mem;
    localparam int W = 8, D = 16, AW = 4;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, scrub_en = 0, inj_en = 0;
    logic [AW-1:0] wr_addr = 0, rd_addr = 0, inj_addr = 0;
    logic [W-1:0] wr_data = 0, inj_mask = 0;
    logic [1:0] inj_sel = 0;
    logic [W-1:0] rd_data;
    logic rd_valid, disagree;

    always #5 clk = ~clk;

    tmr_vote_mem #(.W(W), .D(D), .AW(AW)) u0 (.*);

    // behavioural reference
    logic [W-1:0] m [3][D];
    logic [W-1:0] exp_data = 0;
    logic exp_valid = 0, exp_dis = 0;
    logic pend = 0;
    logic [AW-1:0] pend_addr = 0;
    logic [W-1:0] pend_data = 0;
    int vectors = 0, misses = 0;
    string tag = "R1";

    function automatic logic [W-1:0] vote(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int n;
            n = int'(a[i]) + int'(b[i]) + int'(c[i]);
            r[i] = (n >= 2);
        end
        return r;
    endfunction

    task automatic model_edge();
        logic [W-1:0] ed;
        logic edis, trig;
        ed = exp_data; edis = 0;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) for (int i = 0; i < D; i++) m[k][i] = '0;
            exp_data = 0; exp_valid = 0; exp_dis = 0; pend = 0;
            return;
        end
        if (rd_en) begin
            if (wr_en && wr_addr == rd_addr) ed = wr_data;
            else if (pend && pend_addr == rd_addr) ed = pend_data;
            else begin
                ed = vote(m[0][rd_addr], m[1][rd_addr], m[2][rd_addr]);
                edis = !(m[0][rd_addr] == m[1][rd_addr] && m[0][rd_addr] == m[2][rd_addr]);
            end
        end
        exp_valid = rd_en;
        exp_dis = edis;
        exp_data = ed;
        trig = rd_en && edis && scrub_en;
        if (inj_en && inj_sel != 2'd3) m[inj_sel][inj_addr] = m[inj_sel][inj_addr] ^ inj_mask;
        if (pend) for (int k = 0; k < 3; k++) m[k][pend_addr] = pend_data;
        if (wr_en) for (int k = 0; k < 3; k++) m[k][wr_addr] = wr_data;
        pend = trig;
        if (trig) begin pend_addr = rd_addr; pend_data = ed; end
    endtask

    task automatic compare();
        vectors++;
        if (rd_data !== exp_data || rd_valid !== exp_valid || disagree !== exp_dis) begin
            misses++;
            $display("FAIL %s t=%0t: data/valid/dis = %h/%b/%b expected %h/%b/%b",
                     tag, $time, rd_data, rd_valid, disagree, exp_data, exp_valid, exp_dis);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1 compare();
        wr_en = 0; rd_en = 0; inj_en = 0; scrub_en = 0;
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; cyc();
    endtask
    task automatic do_rd(input logic [AW-1:0] a, input logic s);
        rd_en = 1; rd_addr = a; scrub_en = s; cyc();
    endtask
    task automatic do_inj(input logic [1:0] s, input logic [AW-1:0] a, input logic [W-1:0] mk);
        inj_en = 1; inj_sel = s; inj_addr = a; inj_mask = mk; cyc();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R1";
        cyc(); cyc();
        #2 rst_n = 1;
        cyc();
        do_rd(4'd5, 0); do_rd(4'd15, 0);
        tag = "R2";
        do_wr(4'd2, 8'hA5); do_rd(4'd2, 0); cyc(); cyc();
        tag = "R6";
        do_inj(2'd1, 4'd3, 8'h0F); do_rd(4'd3, 0);
        tag = "R3";
        do_inj(2'd0, 4'd3, 8'h30); do_inj(2'd2, 4'd3, 8'hC0); do_rd(4'd3, 0);
        tag = "R4";
        do_wr(4'd3, 8'h5A); do_rd(4'd3, 0);
        tag = "R5";
        do_inj(2'd0, 4'd4, 8'h01); do_inj(2'd2, 4'd4, 8'h01); do_rd(4'd4, 0);
        tag = "R6";
        do_inj(2'd3, 4'd9, 8'hFF); do_rd(4'd9, 0);
        inj_en = 1; inj_sel = 2'd1; inj_addr = 4'd10; inj_mask = 8'hFF;
        wr_en = 1; wr_addr = 4'd10; wr_data = 8'h77; cyc();
        do_rd(4'd10, 0);
        tag = "R7";
        wr_en = 1; wr_addr = 4'd11; wr_data = 8'hE1; rd_en = 1; rd_addr = 4'd11; cyc();
        do_rd(4'd11, 0);
        tag = "R8";
        do_wr(4'd6, 8'h3C); do_inj(2'd2, 4'd6, 8'hFF);
        do_rd(4'd6, 1); cyc(); do_rd(4'd6, 0);
        do_wr(4'd7, 8'h81); do_inj(2'd0, 4'd7, 8'h18);
        do_rd(4'd7, 0); do_rd(4'd7, 0);
        do_inj(2'd1, 4'd12, 8'h02);
        do_rd(4'd12, 1); do_rd(4'd12, 1); do_rd(4'd12, 0);
        tag = "R9";
        do_wr(4'd8, 8'h11); do_inj(2'd0, 4'd8, 8'h01);
        do_rd(4'd8, 1); do_wr(4'd8, 8'h99); do_rd(4'd8, 0);
        tag = "R10";
        do_wr(4'd13, 8'h44);
        inj_en = 1; inj_sel = 2'd0; inj_addr = 4'd13; inj_mask = 8'hF0;
        rd_en = 1; rd_addr = 4'd13; cyc();
        do_rd(4'd13, 0);
        tag = "R2 R3 R4 R6 R7 R8 R9 R10 random";
        for (int n = 0; n < 3000; n++) begin
            wr_en = ($urandom_range(0, 5) == 0);
            wr_addr = AW'($urandom_range(0, 3));
            wr_data = W'($urandom);
            rd_en = ($urandom_range(0, 1) == 0);
            rd_addr = AW'($urandom_range(0, 3));
            scrub_en = ($urandom_range(0, 2) != 0);
            inj_en = ($urandom_range(0, 2) == 0);
            inj_sel = 2'($urandom_range(0, 3));
            inj_addr = AW'($urandom_range(0, 3));
            inj_mask = W'(1 << $urandom_range(0, W - 1));
            cyc();
        end
        finish_run();
    end
endmodule